// File: doc/BRIEF.md
# SAR ADC Host Conversion Controller

This block runs on the host side of a 16-bit successive-approximation converter that has a parallel output. It drives an active-low start-convert strobe and watches the converter's busy line. It shares a parallel data bus with the converter and gates the bus with active-low chip-select and read. The host programs three counts, all in system clock cycles: the minimum acquisition time, the minimum spacing between conversion starts, and the nominal conversion time. The controller then paces conversions so that a strobe never falls while busy is high. It captures each result and presents it as a 16-bit word with a single-cycle valid pulse. The word is in straight offset-binary or in two's-complement coding.

Three operating styles are latched when the controller leaves idle:
- **Paced, read after conversion.** The result is read as soon as busy falls.
- **Paced, read during the next conversion.** The previous result is read early in the following busy window.
- **Free-running.** The strobe is pulled low once and held low, and the converter restarts by itself.

Once a conversion has started it always runs to completion and is read, even if `enable` is withdrawn. The busy line is asynchronous and passes through a two-flop synchronizer before the state machine sees it.

States and transitions:
- **IDLE → ACQUIRE** on `enable` with busy low (paced).
- **IDLE → START** on `enable` with busy low (free-running).
- **ACQUIRE → START** once both the acquisition count and the period count have been met.
- **ACQUIRE → IDLE** when `enable` drops.
- **START → CONVERT** when synchronized busy is seen high.
- **START → IDLE** when free-running, `enable` is low and busy is low.
- **CONVERT → READ** in two cases: when busy falls, or early in the window for a read during conversion.
- **CONVERT → ACQUIRE** when busy falls in the read-during-conversion style.
- **READ → CONVERT / START / ACQUIRE** after the read cycles, depending on which kind of read it was.

Top module: `sar_host_ctrl`

## Requirements
- R1: After reset, `adc_start_n`, `adc_cs_n` and `adc_rd_n` are high and `res_valid` is low.
- R2: `adc_start_n` never falls while busy is high, and a started conversion is always completed and read even if `enable` drops right after the strobe.
- R3: In the paced styles the strobe, once low, stays low until busy has been seen high, and is then released.
- R4: In the paced styles each strobe fall comes at least `acq_cycles` clock cycles after the preceding busy fall.
- R5: In the paced styles successive strobe falls are at least `period_cycles` clock cycles apart.
- R6: `adc_cs_n` and `adc_rd_n` always switch together and stay low for exactly RD_LEN (default 2) cycles per read.
- R7: With `read_mid`=0, each result is read only after busy falls and appears on `res_data` with a `res_valid` pulse one cycle wide, in conversion order.
- R8: With `read_mid`=1, the result of conversion k is read while conversion k+1 is busy, and the read ends no later than `conv_cycles`/2 cycles after busy rises. The first conversion gives no output in that cycle, and the last conversion's result stays unread after `enable` drops.
- R9: With `read_mid`=1 but `conv_cycles`/2 < RD_LEN+4, every read is deferred until after busy falls, as in R7.
- R10: With `free_run`=1, the strobe falls once and is held low while the converter restarts itself, and every result is read after its busy fall.
- R11: With `twos_comp`=1, bit 15 of the bus word is inverted on `res_data`. With `twos_comp`=0, the word passes unchanged.
- R12: While `enable` is low and the controller is idle, the strobe does not fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run conversions while high |
| free_run | input | 1 | Select the free-running style (latched on leaving idle) |
| read_mid | input | 1 | Select reading during the next conversion (latched on leaving idle) |
| twos_comp | input | 1 | 1: two's-complement output, 0: straight binary |
| acq_cycles | input | 16 | Minimum acquisition time in clock cycles |
| period_cycles | input | 16 | Minimum spacing of strobe falls in clock cycles |
| conv_cycles | input | 16 | Nominal conversion time in clock cycles |
| adc_busy | input | 1 | Converter busy line (asynchronous) |
| adc_data | input | 16 | Shared parallel data bus from the converter |
| adc_start_n | output | 1 | Start-convert strobe, active low |
| adc_cs_n | output | 1 | Chip-select, active low |
| adc_rd_n | output | 1 | Read enable, active low |
| res_valid | output | 1 | One-cycle pulse marking a new result |
| res_data | output | 16 | Captured and coded result |

## Verification
The assertions check the handshake invariants on every cycle:
- the strobe falls only when synchronized busy was low;
- in the paced styles the strobe is released only after busy was seen;
- the acquisition count is met at every paced strobe fall;
- chip-select and read stay paired;
- a read during conversion stays inside the first half of the programmed window;
- an ordinary read never overlaps busy;
- `res_valid` is a single-cycle pulse.

Only the bench's scenarios can show the data path end to end, against a converter model: result order and coding, the one-conversion lag of reads during conversion, deferral when the programmed conversion time is short, the single strobe of free-running operation, and a conversion that still completes after `enable` is pulled away.

// File: rtl/sar_host_pkg.sv
package sar_host_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACQUIRE,
        ST_START,
        ST_CONVERT,
        ST_READ
    } ctl_state_e;

endpackage

// File: rtl/sar_busy_sync.sv
module sar_busy_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level,
    output logic fell
);

    logic [STAGES-1:0] chain;
    logic              level_d;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[0] <= 1'b0;
                else        chain[0] <= async_in;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[i] <= 1'b0;
                else        chain[i] <= chain[i-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) level_d <= 1'b0;
        else        level_d <= chain[STAGES-1];
    end

    assign level = chain[STAGES-1];
    assign fell  = level_d & ~chain[STAGES-1];

endmodule

// File: rtl/sar_gap_counter.sv
module sar_gap_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] count
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             count <= '0;
        else if (clr)           count <= '0;
        else if (count != '1)   count <= count + W'(1);
    end

endmodule

// File: rtl/sar_result_fmt.sv
module sar_result_fmt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap_en,
    input  logic         twos,
    input  logic [W-1:0] bus_in,
    output logic [W-1:0] data_out,
    output logic         valid_out
);

    logic [W-1:0] coded;

    always_comb begin
        coded        = bus_in;
        coded[W-1]   = bus_in[W-1] ^ twos;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_out  <= '0;
            valid_out <= 1'b0;
        end else begin
            valid_out <= cap_en;
            if (cap_en) data_out <= coded;
        end
    end

endmodule

// File: rtl/sar_host_ctrl.sv
module sar_host_ctrl
    import sar_host_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int CNT_W       = 16,
    parameter int RD_LEN      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              free_run,
    input  logic              read_mid,
    input  logic              twos_comp,
    input  logic [CNT_W-1:0]  acq_cycles,
    input  logic [CNT_W-1:0]  period_cycles,
    input  logic [CNT_W-1:0]  conv_cycles,
    input  logic              adc_busy,
    input  logic [DATA_W-1:0] adc_data,
    output logic              adc_start_n,
    output logic              adc_cs_n,
    output logic              adc_rd_n,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_data
);

    // cycles between a busy edge at the pin and the FSM acting on it
    localparam int SYNC_LAT = SYNC_STAGES + 2;
    localparam int RD_W     = $clog2(RD_LEN + 1);

    ctl_state_e        state_q, nxt;
    logic              busy_s, busy_fell;
    logic [CNT_W-1:0]  acq_cnt, per_cnt, conv_cnt;
    logic              fr_q, mid_q, rd_mid_q, have_prev_q;
    logic [RD_W-1:0]   rd_cnt;
    logic              rd_last, mid_ok, fr_n;
    logic              acq_met, per_met, mid_sel;

    // ---------------- submodules ----------------
    sar_busy_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (adc_busy),
        .level    (busy_s),
        .fell     (busy_fell)
    );

    sar_gap_counter #(.W(CNT_W)) u_acq_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_q == ST_IDLE || busy_fell),
        .count (acq_cnt)
    );

    sar_gap_counter #(.W(CNT_W)) u_per_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_q == ST_IDLE || (nxt == ST_START && state_q != ST_START)),
        .count (per_cnt)
    );

    sar_gap_counter #(.W(CNT_W)) u_conv_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_q != ST_CONVERT && state_q != ST_READ),
        .count (conv_cnt)
    );

    sar_result_fmt #(.W(DATA_W)) u_fmt (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_en    (rd_last),
        .twos      (twos_comp),
        .bus_in    (adc_data),
        .data_out  (res_data),
        .valid_out (res_valid)
    );

    // ---------------- decode helpers ----------------
    assign acq_met = (acq_cnt >= acq_cycles);
    assign per_met = (per_cnt >= period_cycles);
    assign mid_ok  = ((conv_cycles >> 1) >= CNT_W'(RD_LEN + SYNC_LAT));
    assign mid_sel = mid_q && !fr_q && mid_ok;
    assign rd_last = (state_q == ST_READ) && (rd_cnt == RD_W'(RD_LEN - 1));
    assign fr_n    = (state_q == ST_IDLE) ? free_run : fr_q;

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= nxt;
    end

    // ---------------- next state ----------------
    always_comb begin
        nxt = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (enable && !busy_s)
                    nxt = free_run ? ST_START : ST_ACQUIRE;
            end
            ST_ACQUIRE: begin
                if (!enable)
                    nxt = ST_IDLE;
                else if (!busy_s && acq_met && per_met)
                    nxt = ST_START;
            end
            ST_START: begin
                if (busy_s)
                    nxt = ST_CONVERT;
                else if (fr_q && !enable)
                    nxt = ST_IDLE;
            end
            ST_CONVERT: begin
                if (!busy_s)
                    nxt = mid_sel ? ST_ACQUIRE : ST_READ;
                else if (mid_sel && have_prev_q)
                    nxt = ST_READ;
            end
            ST_READ: begin
                if (rd_last) begin
                    if (rd_mid_q)  nxt = ST_CONVERT;
                    else if (fr_q) nxt = ST_START;
                    else           nxt = ST_ACQUIRE;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // ---------------- mode and read bookkeeping ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fr_q        <= 1'b0;
            mid_q       <= 1'b0;
            rd_mid_q    <= 1'b0;
            have_prev_q <= 1'b0;
            rd_cnt      <= '0;
        end else begin
            if (state_q == ST_IDLE && nxt != ST_IDLE) begin
                fr_q        <= free_run;
                mid_q       <= read_mid;
                have_prev_q <= 1'b0;
            end
            if (state_q == ST_CONVERT && nxt == ST_READ)
                rd_mid_q <= busy_s;
            if (state_q == ST_CONVERT && nxt == ST_ACQUIRE)
                have_prev_q <= 1'b1;
            else if (rd_last && rd_mid_q)
                have_prev_q <= 1'b0;
            rd_cnt <= (state_q == ST_READ) ? rd_cnt + RD_W'(1) : '0;
        end
    end

    // ---------------- registered pin outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            adc_start_n <= 1'b1;
            adc_cs_n    <= 1'b1;
            adc_rd_n    <= 1'b1;
        end else begin
            adc_start_n <= !(nxt == ST_START || (fr_n && nxt != ST_IDLE));
            adc_cs_n    <= !(nxt == ST_READ);
            adc_rd_n    <= !(nxt == ST_READ);
        end
    end

endmodule

// File: rtl/sar_host_ctrl_chk.sv
module sar_host_ctrl_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             adc_start_n,
    input logic             adc_cs_n,
    input logic             adc_rd_n,
    input logic             res_valid,
    input logic             busy_s,
    input logic             fr_q,
    input logic             rd_mid_q,
    input logic [CNT_W-1:0] acq_cnt,
    input logic [CNT_W-1:0] acq_cycles,
    input logic [CNT_W-1:0] conv_cnt,
    input logic [CNT_W-1:0] conv_cycles
);

    p_start_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_start_n) |-> !$past(busy_s));

    p_hold_until_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!fr_q && $rose(adc_start_n)) |-> $past(busy_s));

    p_acq_met_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!fr_q && $fell(adc_start_n)) |-> ($past(acq_cnt) >= acq_cycles));

    p_pins_paired_r6: assert property (@(posedge clk) disable iff (!rst_n)
        adc_cs_n == adc_rd_n);

    p_valid_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    p_mid_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!adc_rd_n && rd_mid_q) |-> (conv_cnt <= (conv_cycles >> 1)));

    p_late_read_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!adc_rd_n && !rd_mid_q) |-> !busy_s);

endmodule

bind sar_host_ctrl sar_host_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .adc_start_n (adc_start_n),
    .adc_cs_n    (adc_cs_n),
    .adc_rd_n    (adc_rd_n),
    .res_valid   (res_valid),
    .busy_s      (busy_s),
    .fr_q        (fr_q),
    .rd_mid_q    (rd_mid_q),
    .acq_cnt     (acq_cnt),
    .acq_cycles  (acq_cycles),
    .conv_cnt    (conv_cnt),
    .conv_cycles (conv_cycles)
);

// File: tb/sar_host_ctrl_tb.sv
module sar_host_ctrl_tb;

    localparam int CONV_MODEL = 40;
    localparam int FR_ACQ     = 12;
    localparam int RD_LEN     = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0, free_run = 1'b0, read_mid = 1'b0, twos_comp = 1'b0;
    logic [15:0] acq_cycles = 16'd20, period_cycles = 16'd30, conv_cycles = 16'd40;
    logic        adc_busy;
    logic [15:0] adc_data;
    logic        adc_start_n, adc_cs_n, adc_rd_n, res_valid;
    logic [15:0] res_data;

    always #4 clk = ~clk;

    sar_host_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .free_run(free_run),
        .read_mid(read_mid), .twos_comp(twos_comp), .acq_cycles(acq_cycles),
        .period_cycles(period_cycles), .conv_cycles(conv_cycles),
        .adc_busy(adc_busy), .adc_data(adc_data), .adc_start_n(adc_start_n),
        .adc_cs_n(adc_cs_n), .adc_rd_n(adc_rd_n), .res_valid(res_valid),
        .res_data(res_data)
    );

    int total = 0, bad = 0;
    bit done = 0;
    string cur_tag = "R7";
    bit paced = 1;
    bit expect_mid = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // ---------------- converter model and scoreboard driver ----------------
    logic [15:0] exp_q[$];
    logic [15:0] last_result, sample;
    logic [15:0] sample_ctr;
    int          conv_left, auto_left;
    bit          auto_arm, prev_sn;

    assign adc_data = (!adc_cs_n && !adc_rd_n) ? last_result : 16'hDEAD;

    always @(posedge clk) begin
        if (!rst_n) begin
            adc_busy <= 1'b0; conv_left <= 0; auto_left <= 0; auto_arm <= 0;
            prev_sn <= 1'b1; last_result <= 16'h0000; sample <= 16'h0; sample_ctr <= 16'h0;
        end else begin
            prev_sn <= adc_start_n;
            if (adc_start_n) auto_arm <= 0;
            if (!adc_busy) begin
                if ((prev_sn && !adc_start_n) || (auto_arm && auto_left == 0 && !adc_start_n)) begin
                    adc_busy   <= 1'b1;
                    conv_left  <= CONV_MODEL - 1;
                    sample     <= sample_ctr * 16'h2B3D + 16'h8415;
                    sample_ctr <= sample_ctr + 16'd1;
                    auto_arm   <= 0;
                end else if (auto_arm && auto_left > 0) begin
                    auto_left <= auto_left - 1;
                end
            end else begin
                if (conv_left == 0) begin
                    adc_busy    <= 1'b0;
                    last_result <= sample;
                    exp_q.push_back(sample ^ {twos_comp, 15'b0});
                    if (!adc_start_n) begin
                        auto_arm  <= 1;
                        auto_left <= FR_ACQ;
                    end
                end else begin
                    conv_left <= conv_left - 1;
                end
            end
        end
    end

    // ---------------- monitor ----------------
    int  cyc = 0, pops = 0, falls = 0, mid_reads = 0, busy_reads = 0, pair_err = 0;
    int  t_bfall, t_brise, t_sfall, t_rd;
    bit  have_bfall, have_sfall;
    bit  m_sn, m_rd, m_busy;

    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_sn = 1; m_rd = 1; m_busy = 0; have_bfall = 0; have_sfall = 0;
        end else begin
            if (res_valid) begin
                if (exp_q.size() == 0) begin
                    chk(0, {cur_tag, " unexpected result"}, res_data, 0);
                end else begin
                    automatic logic [15:0] e = exp_q.pop_front();
                    chk(res_data == e, {cur_tag, " result value"}, res_data, e);
                end
                pops++;
            end
            if (m_busy && !adc_busy) begin t_bfall = cyc; have_bfall = 1; end
            if (!m_busy && adc_busy) t_brise = cyc;
            if (m_sn && !adc_start_n) begin
                falls++;
                chk(!adc_busy, "R2 strobe fell while busy", adc_busy, 0);
                if (paced && have_bfall)
                    chk(cyc - t_bfall >= acq_cycles, "R4 acquisition gap", cyc - t_bfall, acq_cycles);
                if (paced && have_sfall)
                    chk(cyc - t_sfall >= period_cycles, "R5 start spacing", cyc - t_sfall, period_cycles);
                t_sfall = cyc; have_sfall = 1;
            end
            if (paced && !m_sn && adc_start_n)
                chk(adc_busy, "R3 strobe released before busy", adc_busy, 1);
            if (adc_cs_n != adc_rd_n) pair_err++;
            if (m_rd && !adc_rd_n) t_rd = cyc;
            if (!m_rd && adc_rd_n) begin
                chk(cyc - t_rd == RD_LEN, "R6 read length", cyc - t_rd, RD_LEN);
                if (adc_busy) begin
                    if (expect_mid) begin
                        mid_reads++;
                        chk(cyc - t_brise <= conv_cycles / 2, "R8 mid read window",
                            cyc - t_brise, conv_cycles / 2);
                    end else begin
                        busy_reads++;
                    end
                end
            end
            m_sn = adc_start_n; m_rd = adc_rd_n; m_busy = adc_busy;
        end
    end

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        if (cyc > 150000 && !done) begin
            done = 1;
            bad++; total++;
            $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // ---------------- scenarios ----------------
    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; enable = 0;
        repeat (4) @(negedge clk);
        exp_q.delete();
        pops = 0; falls = 0; mid_reads = 0; busy_reads = 0; pair_err = 0;
        rst_n = 1;
        @(negedge clk);
    endtask

    task automatic run(input string tag, input bit fr, input bit mid, input bit tc,
                       input int acq, input int per, input int cv, input int n, input int left);
        free_run = fr; read_mid = mid; twos_comp = tc;
        acq_cycles = 16'(acq); period_cycles = 16'(per); conv_cycles = 16'(cv);
        cur_tag = tag; paced = !fr;
        expect_mid = mid && !fr && (cv / 2 >= RD_LEN + 4);
        do_reset();
        enable = 1;
        for (int w = 0; w < 20000 && pops < n; w++) @(negedge clk);
        enable = 0;
        repeat (300) @(negedge clk);
        chk(pops >= n, {tag, " result count"}, pops, n);
        chk(exp_q.size() == left, {tag, " unread results"}, exp_q.size(), left);
        chk(pair_err == 0, "R6 cs/rd pairing", pair_err, 0);
        chk(busy_reads == 0, {tag, " read while busy"}, busy_reads, 0);
        if (expect_mid) chk(mid_reads >= n - 1, "R8 mid reads seen", mid_reads, n - 1);
        if (fr)         chk(falls == 1, "R10 single strobe", falls, 1);
    endtask

    initial begin
        // R1 reset state, R12 no strobe while disabled
        do_reset();
        chk(adc_start_n == 1, "R1 start_n", adc_start_n, 1);
        chk(adc_cs_n == 1,    "R1 cs_n",    adc_cs_n, 1);
        chk(adc_rd_n == 1,    "R1 rd_n",    adc_rd_n, 1);
        chk(res_valid == 0,   "R1 valid",   res_valid, 0);
        repeat (100) @(negedge clk);
        chk(falls == 0, "R12 no strobe when disabled", falls, 0);

        run("R7",  0, 0, 0, 20, 30,  40, 5, 0);   // read after convert, acq-limited
        run("R11", 0, 0, 1, 10, 150, 40, 4, 0);   // two's complement, period-limited
        run("R8",  0, 1, 0, 20, 30,  40, 4, 1);   // read during next conversion
        run("R9",  0, 1, 1, 20, 30,  10, 4, 0);   // short window: deferred reads
        run("R10", 1, 0, 0, 20, 30,  40, 5, 0);   // free-running

        // R2: enable dropped right after the strobe, conversion still completes
        free_run = 0; read_mid = 0; twos_comp = 0;
        acq_cycles = 16'd5; period_cycles = 16'd5; conv_cycles = 16'd40;
        cur_tag = "R2"; paced = 1; expect_mid = 0;
        do_reset();
        enable = 1;
        for (int w = 0; w < 2000 && adc_start_n; w++) @(negedge clk);
        enable = 0;
        repeat (300) @(negedge clk);
        chk(pops == 1, "R2 started conversion read", pops, 1);
        chk(exp_q.size() == 0, "R2 nothing left", exp_q.size(), 0);
        chk(falls == 1, "R2 no restart after disable", falls, 1);

        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule